// File: doc/BRIEF.md
# Configurable Registered Output Macrocell

This block is one input/output cell of a small sum-of-products logic device. It receives the OR-plane sum for its pin, its own output-enable product term, and the clear and preset terms that every cell in the device shares. Two configuration bits choose how the cell behaves. One picks registered or combinational operation. The other picks active-high or active-low output polarity.

In registered mode a rising-edge D flip-flop captures the sum. The shared preset term forces the flip-flop high at the next clock edge. The shared clear term forces it low at once, without waiting for a clock, and clear takes priority over preset. The chosen value passes through the polarity stage to a tri-state driver, which is modelled as a data output plus a drive-enable output. A feedback selector returns a value to the logic array. In registered mode it returns the flip-flop state. In combinational mode it returns the level seen on the pin. Because of this, the output-enable term decides whether a combinational cell works as a dedicated output, a dedicated input or a bidirectional pin.

A power-on reset input clears the flip-flop, so the level on the pin after power-up depends only on the programmed polarity.

Top module: `prog_macrocell`

## Requirements
- R1: While `por_n` is low, the flip-flop is 0. With `cfg_registered`=1 this gives `fb_out`=0, `pin_out`=0 when `cfg_active_high`=1, and `pin_out`=1 when `cfg_active_high`=0.
- R2: In registered mode with clear and preset low, the flip-flop takes `sum_term` on the rising edge of `clk`. Changing `sum_term` between edges does not alter `fb_out`.
- R3: When `pre_term` is high and `clr_term` is low, the flip-flop becomes 1 at the next rising edge and not earlier. Preset overrides `sum_term`.
- R4: When `clr_term` goes high, the flip-flop goes to 0 at once, without waiting for a clock edge, and stays 0 while `clr_term` is high.
- R5: When `clr_term` and `pre_term` are both high across a clock edge, the flip-flop stays 0.
- R6: `pin_out` is the selected core value when `cfg_active_high`=1 and its inverse when `cfg_active_high`=0. The core value is the flip-flop in registered mode and `sum_term` in combinational mode.
- R7: In combinational mode (`cfg_registered`=0), `pin_out` follows `sum_term` without a clock edge.
- R8: `pin_oe` equals `oe_term`. When it is 0, the pin is high-impedance and `pin_in` gives the external level.
- R9: In registered mode, `fb_out` is the flip-flop state whatever the values of `pin_in` and `oe_term`.
- R10: In combinational mode, `fb_out` is the pin level: `pin_out` when `oe_term`=1, and `pin_in` when `oe_term`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flop; capture happens on the rising edge |
| por_n | input | 1 | Power-on reset, active low and asynchronous; clears the flip-flop |
| sum_term | input | 1 | OR-plane sum for this cell |
| oe_term | input | 1 | Output-enable product term |
| clr_term | input | 1 | Shared clear term; asynchronous and takes priority |
| pre_term | input | 1 | Shared preset term; synchronous |
| cfg_registered | input | 1 | 1 selects registered mode, 0 selects combinational mode |
| cfg_active_high | input | 1 | 1 selects active-high output, 0 selects active-low output |
| pin_in | input | 1 | External level on the pin, read when the driver is off |
| pin_out | output | 1 | Value the driver places on the pin |
| pin_oe | output | 1 | Driver enable; 0 means the pin is high-impedance |
| fb_out | output | 1 | Feedback value returned to the logic array |

## Verification
The hardest case to reach is a clear that rises in the middle of a clock period while preset is already pending. The bench first loads a 1 into the flip-flop. It then raises `clr_term` at a point between two clock edges and samples `fb_out` before the next edge arrives, which shows that clear acts at once. Next it holds `pre_term` and `sum_term` high across that edge with clear still asserted, which shows that clear wins over preset. A second hard case is a high-impedance pin in combinational mode. Here the bench drives `pin_in` opposite to the cell's own output value, so `fb_out` shows which of the two the selector returned.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    // Static configuration of one cell
    typedef struct packed {
        logic registered;
        logic active_high;
    } mcell_cfg_t;

    // State held by the storage element
    typedef struct packed {
        logic q;
    } mcell_state_t;

    // Output polarity stage
    function automatic logic apply_polarity(input logic value, input logic active_high);
        return active_high ? value : ~value;
    endfunction

endpackage

// File: rtl/mcell_reg.sv
module mcell_reg
    import mcell_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic d_in,
    input  logic clr_term,
    input  logic pre_term,
    output logic q_out
);

    mcell_state_t state_d;
    mcell_state_t state_q;

    // Next-state logic: a pending preset overrides the data input
    always_comb begin
        state_d   = state_q;
        state_d.q = pre_term ? 1'b1 : d_in;
    end

    // Clear and power-on reset act without a clock and beat everything else
    always_ff @(posedge clk or posedge clr_term or negedge por_n) begin
        if (!por_n || clr_term) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_out = state_q.q;

endmodule

// File: rtl/mcell_drive.sv
module mcell_drive
    import mcell_pkg::*;
(
    input  mcell_cfg_t cfg,
    input  logic       reg_q,
    input  logic       sum_term,
    input  logic       oe_term,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       pin_level
);

    logic core_val;

    always_comb begin
        core_val  = cfg.registered ? reg_q : sum_term;
        pin_out   = apply_polarity(core_val, cfg.active_high);
        pin_oe    = oe_term;
        // Level on the pin: the cell's own driver, or whatever is outside when the driver is off
        pin_level = oe_term ? pin_out : pin_in;
    end

endmodule

// File: rtl/mcell_fbsel.sv
module mcell_fbsel
    import mcell_pkg::*;
(
    input  mcell_cfg_t cfg,
    input  logic       reg_q,
    input  logic       pin_level,
    output logic       fb_out
);

    always_comb begin
        fb_out = cfg.registered ? reg_q : pin_level;
    end

endmodule

// File: rtl/prog_macrocell.sv
module prog_macrocell
    import mcell_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sum_term,
    input  logic oe_term,
    input  logic clr_term,
    input  logic pre_term,
    input  logic cfg_registered,
    input  logic cfg_active_high,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_out
);

    mcell_cfg_t cfg;
    logic       reg_q;
    logic       pin_level;

    assign cfg.registered  = cfg_registered;
    assign cfg.active_high = cfg_active_high;

    mcell_reg u_reg (
        .clk      (clk),
        .por_n    (por_n),
        .d_in     (sum_term),
        .clr_term (clr_term),
        .pre_term (pre_term),
        .q_out    (reg_q)
    );

    mcell_drive u_drive (
        .cfg       (cfg),
        .reg_q     (reg_q),
        .sum_term  (sum_term),
        .oe_term   (oe_term),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_level (pin_level)
    );

    mcell_fbsel u_fbsel (
        .cfg       (cfg),
        .reg_q     (reg_q),
        .pin_level (pin_level),
        .fb_out    (fb_out)
    );

endmodule

// File: rtl/mcell_checker.sv
module mcell_checker (
    input logic clk,
    input logic por_n,
    input logic sum_term,
    input logic oe_term,
    input logic clr_term,
    input logic pre_term,
    input logic cfg_registered,
    input logic cfg_active_high,
    input logic pin_in,
    input logic pin_out,
    input logic pin_oe,
    input logic fb_out,
    input logic reg_q
);

    // R1
    always_comb begin
        if (!por_n) begin
            reset_low_chk: assert (reg_q == 1'b0);
        end
    end

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_term && !pre_term) |=> (clr_term || reg_q == $past(sum_term)));

    // R3
    preset_chk: assert property (@(posedge clk) disable iff (!por_n)
        (pre_term && !clr_term) |=> (clr_term || reg_q));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        clr_term |-> !reg_q);

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_term && pre_term) |=> (!clr_term || !reg_q));

    // R6
    polarity_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_registered |-> (pin_out == (cfg_active_high ? reg_q : !reg_q)));

    // R9
    reg_fb_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_registered |-> (fb_out == reg_q));

    // R10
    comb_fb_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!cfg_registered && !pin_oe) |-> (fb_out == pin_in));

endmodule

bind prog_macrocell mcell_checker u_chk (
    .clk             (clk),
    .por_n           (por_n),
    .sum_term        (sum_term),
    .oe_term         (oe_term),
    .clr_term        (clr_term),
    .pre_term        (pre_term),
    .cfg_registered  (cfg_registered),
    .cfg_active_high (cfg_active_high),
    .pin_in          (pin_in),
    .pin_out         (pin_out),
    .pin_oe          (pin_oe),
    .fb_out          (fb_out),
    .reg_q           (reg_q)
);

// File: tb/prog_macrocell_test.sv
`timescale 1ns/1ps
module prog_macrocell_test;

    logic clk = 1'b0;
    logic por_n, sum_term, oe_term, clr_term, pre_term;
    logic cfg_registered, cfg_active_high, pin_in;
    logic pin_out, pin_oe, fb_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    prog_macrocell uut (
        .clk             (clk),
        .por_n           (por_n),
        .sum_term        (sum_term),
        .oe_term         (oe_term),
        .clr_term        (clr_term),
        .pre_term        (pre_term),
        .cfg_registered  (cfg_registered),
        .cfg_active_high (cfg_active_high),
        .pin_in          (pin_in),
        .pin_out         (pin_out),
        .pin_oe          (pin_oe),
        .fb_out          (fb_out)
    );

    // Combinational-mode vectors: {active_high, oe, sum, pin_in, exp_pin_out, exp_fb}
    localparam logic [5:0] VEC [8] = '{
        6'b1_1_0_0_0_0,
        6'b1_1_1_0_1_1,
        6'b0_1_1_1_0_0,
        6'b0_1_0_0_1_1,
        6'b1_0_1_0_1_0,
        6'b1_0_0_1_0_1,
        6'b0_0_0_0_1_0,
        6'b0_0_1_1_0_1
    };

    task automatic check(input string req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        por_n = 1'b0; sum_term = 1'b1; oe_term = 1'b1; clr_term = 1'b0; pre_term = 1'b0;
        cfg_registered = 1'b1; cfg_active_high = 1'b1; pin_in = 1'b0;
        repeat (2) @(negedge clk);
        // R1: power-on state under both polarities
        check("R1 fb", fb_out, 1'b0);
        check("R1 pin active-high", pin_out, 1'b0);
        cfg_active_high = 1'b0;
        #1 check("R1 pin active-low", pin_out, 1'b1);
        cfg_active_high = 1'b1;

        // Combinational table: R6 R7 R8 R10
        @(negedge clk);
        por_n = 1'b1;
        cfg_registered = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cfg_active_high = VEC[i][5];
            oe_term  = VEC[i][4];
            sum_term = VEC[i][3];
            pin_in   = VEC[i][2];
            #1;
            check("R7/R6 pin_out", pin_out, VEC[i][1]);
            check("R8 pin_oe", pin_oe, VEC[i][4]);
            check("R10 fb", fb_out, VEC[i][0]);
        end

        // R2: registered capture on the rising edge only
        @(negedge clk);
        cfg_registered = 1'b1; cfg_active_high = 1'b1; oe_term = 1'b1; sum_term = 1'b0; pin_in = 1'b0;
        @(negedge clk);
        check("R2 loaded 0", fb_out, 1'b0);
        sum_term = 1'b1;
        #1 check("R2 no change before edge", fb_out, 1'b0);
        @(negedge clk);
        check("R2 captured 1", fb_out, 1'b1);
        check("R6 active-high registered", pin_out, 1'b1);
        cfg_active_high = 1'b0;
        #1 check("R6 active-low registered", pin_out, 1'b0);
        cfg_active_high = 1'b1;

        // R9: registered feedback ignores the pin
        oe_term = 1'b0; pin_in = 1'b0;
        #1 check("R9 fb ignores pin_in", fb_out, 1'b1);
        sum_term = 1'b0; pin_in = 1'b1;
        @(negedge clk);
        check("R9 fb follows register", fb_out, 1'b0);
        oe_term = 1'b1; pin_in = 1'b0;

        // R3: synchronous preset overrides sum
        pre_term = 1'b1;
        #1 check("R3 not before edge", fb_out, 1'b0);
        @(negedge clk);
        check("R3 set at edge", fb_out, 1'b1);
        pre_term = 1'b0; sum_term = 1'b1;
        @(negedge clk);
        check("R3 holds 1", fb_out, 1'b1);

        // R4: clear rising mid-cycle acts at once
        #1 clr_term = 1'b1;
        #1 check("R4 immediate clear", fb_out, 1'b0);
        check("R4 pin active-high", pin_out, 1'b0);

        // R5: clear and preset together across an edge
        pre_term = 1'b1; sum_term = 1'b1;
        @(negedge clk);
        check("R5 clear beats preset", fb_out, 1'b0);
        clr_term = 1'b0; pre_term = 1'b0;
        @(negedge clk);
        check("R2 recovers after clear", fb_out, 1'b1);

        finish_run();
    end

endmodule